// File: doc/BRIEF.md
# Two-Phase Software-Filled Translation Buffer

This block is a small fully associative address translation buffer whose contents are written entirely by system software. Each mapping is installed in two separate commands. The first command, an address insert, names a virtual address and supplies the physical frame. It removes any live mapping that already covers that address, picks a slot, and records the page range and frame while the slot stays unusable. The second command, a protection insert to the same address, supplies the access-rights word and makes the entry live. A protection insert that does not find a matching pending entry is dropped and flagged.

A separate combinational lookup port takes a virtual address and an access kind. It returns either the physical address and the stored rights, or a miss, which is reported as an instruction miss or a data miss. Pages are 4 KiB and the buffer holds 16 entries. Both sizes are parameters.

Top module: `swTlb`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves every entry unable to match any address and sets the eviction pointer to slot 0. After reset, every lookup misses.
- R2: An entry matches a lookup address when the address lies between the entry's begin and end addresses, inclusive. A page therefore matches at offset 0x000 and at 0xFFF, and does not match on the next page. On a hit, `lkPa` is the stored frame followed by the 12 offset bits of `lkVa`. When several entries match, the lowest-index match decides the result.
- R3: With `lkReq` high and no live match (no match at all, or a lowest-index match that is not yet valid), `lkMissData` is raised when `lkIsData` is 1 and `lkMissInstr` is raised when it is 0. The two are never high together. On a miss, `lkPa` and `lkRights` are zero.
- R4: An address insert (`cmdIsProt`=0) leaves the new entry invalid, so lookups of that page miss until a protection insert arrives.
- R5: An address insert first clears every valid entry whose range covers the command address, so the old mapping stops hitting.
- R6: An address insert places the mapping in the highest-index slot that is either invalid or was just cleared by the same command. A valid entry is never evicted while such a slot exists.
- R7: When no such slot exists, the entry at the eviction pointer is replaced and the pointer advances by one, wrapping from the last index to 0.
- R8: The frame number is taken from bits 24..5 of `cmdData` (bit 0 is the least significant) and placed above the 12-bit page offset.
- R9: A protection insert (`cmdIsProt`=1) finds the lowest-index entry covering `cmdVa`. If that entry is invalid, it stores `cmdData` bits 29..1 as the rights and makes the entry valid. `lkRights[k]` equals data bit k+1: access id in [17:0], U in [18], privilege level 2 in [20:19], privilege level 1 in [22:21], access type in [25:23], B in [26], D in [27] and T in [28].
- R10: A protection insert that finds no covering entry, or finds a covering entry that is already valid, changes nothing and raises `seqErr` together with `cmdDone`.
- R11: A command is accepted when `cmdValid` is high at an edge while the block is idle. `cmdDone` is high for exactly the next cycle, and the buffer update takes effect at the edge that ends that cycle. A `cmdValid` seen during the `cmdDone` cycle is ignored.
- R12: Clearing an entry, whether by a covering address insert, by eviction or by reset, erases its frame and rights, so no lookup can see the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command request |
| cmdIsProt | input | 1 | 0 = address insert, 1 = protection insert |
| cmdVa | input | VA_W | Command virtual address |
| cmdData | input | 32 | Frame word or rights word |
| cmdDone | output | 1 | One-cycle completion pulse |
| seqErr | output | 1 | Protection insert dropped (valid with cmdDone) |
| lkReq | input | 1 | Lookup request qualifying the miss outputs |
| lkIsData | input | 1 | 1 = data access, 0 = instruction fetch |
| lkVa | input | VA_W | Lookup virtual address |
| lkHit | output | 1 | Live entry matched |
| lkMissInstr | output | 1 | Instruction miss |
| lkMissData | output | 1 | Data miss |
| lkPa | output | 32 | Translated physical address |
| lkRights | output | 29 | Stored rights of the hit entry |

## Verification
The insert and lookup sequence is driven with four patterns. Ordinary address-then-protection pairs with page-edge lookups separate range and offset errors. Out-of-order protection inserts and repeated address inserts on a live page show whether stale entries are cleared and whether the sequencing error is raised. Sixteen-plus-one and thirty-three page fills show free-slot preference apart from round-robin eviction and its wrap. A random mix over 24 pages, with more pages than slots, produces overlapping pending entries and evictions in orders that the directed cases do not reach.

// File: rtl/swTlbPkg.sv
package swTlbPkg;

  // fixed layout of the command data word
  localparam int DATA_W    = 32;
  localparam int FRAME_LO  = 5;
  localparam int FRAME_W   = 20;
  localparam int RIGHTS_LO = 1;
  localparam int RIGHTS_W  = 29;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;       // latch command address and data
    logic clearCovered;  // clear valid entries covering the latched address
    logic writeAddr;     // install range and frame into the chosen slot
    logic writeProt;     // install rights and validate the chosen slot
  } tlbStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } tlbState_t;

endpackage

// File: rtl/swTlbData.sv
module swTlbData
  import swTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tlbStrobes_t          strb,
  input  logic [IDX_W-1:0]     slot,
  input  logic [VA_W-1:0]      cmdVa,
  input  logic [DATA_W-1:0]    cmdData,
  input  logic [VA_W-1:0]      lkVa,
  output logic [ENTRIES-1:0]   coverVec,
  output logic [ENTRIES-1:0]   validVec,
  output logic                 lkHit,
  output logic [FRAME_W+OFF_W-1:0] lkPa,
  output logic [RIGHTS_W-1:0]  lkRights
);

  localparam int PA_W = FRAME_W + OFF_W;

  logic [VA_W-1:0]     vBegin [ENTRIES];
  logic [VA_W-1:0]     vEnd   [ENTRIES];
  logic [FRAME_W-1:0]  frame  [ENTRIES];
  logic [RIGHTS_W-1:0] rights [ENTRIES];

  logic [VA_W-1:0]     cmdVaQ;
  logic [FRAME_W-1:0]  frameQ;
  logic [RIGHTS_W-1:0] rightsQ;
  logic [1:0]          unusedDataBits;

  logic [VA_W-1:0]     newBegin;
  logic [VA_W-1:0]     newEnd;
  logic [ENTRIES-1:0]  lkMatchVec;
  logic [IDX_W-1:0]    lkIdx;
  logic                lkAny;

  assign unusedDataBits = {^cmdData[DATA_W-1:FRAME_LO+FRAME_W], cmdData[0]};

  // command capture
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdVaQ  <= '0;
      frameQ  <= '0;
      rightsQ <= '0;
    end else if (strb.capture) begin
      cmdVaQ  <= cmdVa;
      frameQ  <= cmdData[FRAME_LO +: FRAME_W];
      rightsQ <= cmdData[RIGHTS_LO +: RIGHTS_W];
    end
  end

  assign newBegin = {cmdVaQ[VA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign newEnd   = {cmdVaQ[VA_W-1:OFF_W], {OFF_W{1'b1}}};

  // range compare per entry, for the command and for the lookup
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign coverVec[e]   = (vBegin[e] <= cmdVaQ) && (cmdVaQ <= vEnd[e]);
      assign lkMatchVec[e] = (vBegin[e] <= lkVa) && (lkVa <= vEnd[e]);
    end
  endgenerate

  // entry storage
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst || (strb.clearCovered && coverVec[e] && validVec[e])) begin
        vBegin[e]   <= '1;
        vEnd[e]     <= '0;
        frame[e]    <= '0;
        rights[e]   <= '0;
        validVec[e] <= 1'b0;
      end
      if (!rst && strb.writeAddr && (slot == IDX_W'(e))) begin
        vBegin[e]   <= newBegin;
        vEnd[e]     <= newEnd;
        frame[e]    <= frameQ;
        rights[e]   <= '0;
        validVec[e] <= 1'b0;
      end
      if (!rst && strb.writeProt && (slot == IDX_W'(e))) begin
        rights[e]   <= rightsQ;
        validVec[e] <= 1'b1;
      end
    end
  end

  // lowest-index lookup match
  always_comb begin
    lkIdx = '0;
    lkAny = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (lkMatchVec[e]) begin
        lkIdx = IDX_W'(e);
        lkAny = 1'b1;
      end
    end
  end

  assign lkHit    = lkAny && validVec[lkIdx];
  assign lkPa     = lkHit ? {frame[lkIdx], lkVa[OFF_W-1:0]} : PA_W'(0);
  assign lkRights = lkHit ? rights[lkIdx] : '0;

endmodule

// File: rtl/swTlbCtrl.sv
module swTlbCtrl
  import swTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  input  logic               cmdIsProt,
  input  logic [ENTRIES-1:0] coverVec,
  input  logic [ENTRIES-1:0] validVec,
  output tlbStrobes_t        strb,
  output logic [IDX_W-1:0]   slot,
  output logic               cmdDone,
  output logic               seqErr,
  output logic [IDX_W-1:0]   rrPtr
);

  tlbState_t          state;
  logic               isProtQ;
  logic               evict;

  logic [ENTRIES-1:0] candVec;
  logic               candAny;
  logic [IDX_W-1:0]   candIdx;
  logic               protAny;
  logic [IDX_W-1:0]   protIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      isProtQ <= 1'b0;
      rrPtr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state   <= ST_EXEC;
            isProtQ <= cmdIsProt;
          end
        end
        default: begin
          state <= ST_IDLE;
          if (evict) begin
            rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
          end
        end
      endcase
    end
  end

  // slot candidates for an address insert: free or about to be cleared
  assign candVec = ~validVec | (coverVec & validVec);
  assign candAny = |candVec;

  always_comb begin
    candIdx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (candVec[e]) candIdx = IDX_W'(e);
    end
  end

  // lowest covering entry for a protection insert
  always_comb begin
    protIdx = '0;
    protAny = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (coverVec[e]) begin
        protIdx = IDX_W'(e);
        protAny = 1'b1;
      end
    end
  end

  always_comb begin
    strb         = '0;
    slot         = '0;
    evict        = 1'b0;
    seqErr       = 1'b0;
    cmdDone      = (state == ST_EXEC);
    strb.capture = (state == ST_IDLE) && cmdValid;
    if (state == ST_EXEC) begin
      if (isProtQ) begin
        if (protAny && !validVec[protIdx]) begin
          strb.writeProt = 1'b1;
          slot           = protIdx;
        end else begin
          seqErr = 1'b1;
        end
      end else begin
        strb.clearCovered = 1'b1;
        strb.writeAddr    = 1'b1;
        if (candAny) begin
          slot = candIdx;
        end else begin
          slot  = rrPtr;
          evict = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/swTlb.sv
module swTlb
  import swTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic                cmdIsProt,
  input  logic [VA_W-1:0]     cmdVa,
  input  logic [DATA_W-1:0]   cmdData,
  output logic                cmdDone,
  output logic                seqErr,
  input  logic                lkReq,
  input  logic                lkIsData,
  input  logic [VA_W-1:0]     lkVa,
  output logic                lkHit,
  output logic                lkMissInstr,
  output logic                lkMissData,
  output logic [PA_W-1:0]     lkPa,
  output logic [RIGHTS_W-1:0] lkRights
);

  tlbStrobes_t        strb;
  logic [IDX_W-1:0]   slot;
  logic [IDX_W-1:0]   rrPtr;
  logic [ENTRIES-1:0] coverVec;
  logic [ENTRIES-1:0] validVec;

  swTlbCtrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdIsProt(cmdIsProt),
    .coverVec (coverVec),
    .validVec (validVec),
    .strb     (strb),
    .slot     (slot),
    .cmdDone  (cmdDone),
    .seqErr   (seqErr),
    .rrPtr    (rrPtr)
  );

  swTlbData #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .VA_W(VA_W), .OFF_W(OFF_W)) data_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .slot    (slot),
    .cmdVa   (cmdVa),
    .cmdData (cmdData),
    .lkVa    (lkVa),
    .coverVec(coverVec),
    .validVec(validVec),
    .lkHit   (lkHit),
    .lkPa    (lkPa),
    .lkRights(lkRights)
  );

  assign lkMissInstr = lkReq && !lkHit && !lkIsData;
  assign lkMissData  = lkReq && !lkHit && lkIsData;

endmodule

// File: rtl/swTlbChecker.sv
module swTlbChecker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmdValid,
  input logic             cmdDone,
  input logic             seqErr,
  input logic             lkMissInstr,
  input logic             lkMissData,
  input logic [IDX_W-1:0] rrPtr
);

  // R1: pointer starts at slot 0 once reset is released
  assert_rr_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rrPtr == '0));

  // R3: a miss is of one kind only
  assert_miss_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(lkMissInstr && lkMissData));

  // R7: the eviction pointer moves only on a completing command
  assert_rr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !cmdDone |=> $stable(rrPtr));

  // R10: sequencing error only together with completion
  assert_seqerr_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    seqErr |-> cmdDone);

  // R11: an accepted command completes in the next cycle
  assert_done_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdDone) |=> cmdDone);

  // R11: completion is a single-cycle pulse
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    cmdDone |=> !cmdDone);

endmodule

bind swTlb swTlbChecker #(.IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmdValid   (cmdValid),
  .cmdDone    (cmdDone),
  .seqErr     (seqErr),
  .lkMissInstr(lkMissInstr),
  .lkMissData (lkMissData),
  .rrPtr      (rrPtr)
);

// File: tb/swTlb_tb_top.sv
`timescale 1ns/1ps
module swTlb_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdIsProt = 1'b0;
  logic [31:0] cmdVa = '0;
  logic [31:0] cmdData = '0;
  logic        cmdDone;
  logic        seqErr;
  logic        lkReq = 1'b0;
  logic        lkIsData = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkHit;
  logic        lkMissInstr;
  logic        lkMissData;
  logic [31:0] lkPa;
  logic [28:0] lkRights;

  int nVec = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0] mBeg [N];
  logic [31:0] mEnd [N];
  logic [19:0] mFrm [N];
  logic [28:0] mRts [N];
  bit          mVal [N];
  int          mRr;

  swTlb dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdIsProt(cmdIsProt),
    .cmdVa(cmdVa), .cmdData(cmdData), .cmdDone(cmdDone), .seqErr(seqErr),
    .lkReq(lkReq), .lkIsData(lkIsData), .lkVa(lkVa), .lkHit(lkHit),
    .lkMissInstr(lkMissInstr), .lkMissData(lkMissData), .lkPa(lkPa),
    .lkRights(lkRights)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] pageVa(input int pg, input int off);
    return 32'h4000_0000 | (32'(pg) << 12) | 32'(off & 12'hFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mClear(input int e);
    mBeg[e] = '1; mEnd[e] = '0; mFrm[e] = '0; mRts[e] = '0; mVal[e] = 1'b0;
  endtask

  task automatic mReset();
    for (int e = 0; e < N; e++) mClear(e);
    mRr = 0;
  endtask

  function automatic int mFind(input logic [31:0] va);
    for (int e = 0; e < N; e++)
      if (mBeg[e] <= va && va <= mEnd[e]) return e;
    return -1;
  endfunction

  task automatic mAddr(input logic [31:0] va, input logic [31:0] data);
    int cand = -1;
    for (int e = 0; e < N; e++) begin
      if (!mVal[e]) cand = e;
      else if (mBeg[e] <= va && va <= mEnd[e]) begin
        mClear(e);
        cand = e;
      end
    end
    if (cand < 0) begin
      cand = mRr;
      mRr = (mRr == N - 1) ? 0 : mRr + 1;
    end
    mClear(cand);
    mBeg[cand] = {va[31:12], 12'h000};
    mEnd[cand] = {va[31:12], 12'hFFF};
    mFrm[cand] = data[24:5];
  endtask

  task automatic mProt(input logic [31:0] va, input logic [31:0] data, output bit err);
    int e = mFind(va);
    if (e < 0 || mVal[e]) err = 1'b1;
    else begin
      err = 1'b0;
      mRts[e] = data[29:1];
      mVal[e] = 1'b1;
    end
  endtask

  task automatic doCmd(input bit isProt, input logic [31:0] va,
                       input logic [31:0] data, input bit hold);
    bit expErr = 1'b0;
    @(negedge clk);
    cmdValid = 1'b1; cmdIsProt = isProt; cmdVa = va; cmdData = data;
    @(negedge clk);
    if (!hold) cmdValid = 1'b0;
    if (isProt) mProt(va, data, expErr);
    else mAddr(va, data);
    chk(cmdDone == 1'b1, "R11", "done pulse", 64'(cmdDone), 64'd1);
    chk(seqErr == expErr, isProt ? "R10" : "R11", "seqErr", 64'(seqErr), 64'(expErr));
    @(negedge clk);
    cmdValid = 1'b0;
    chk(cmdDone == 1'b0, "R11", "done low after pulse", 64'(cmdDone), 64'd0);
  endtask

  task automatic look(input logic [31:0] va, input bit isData, input string tag);
    int idx;
    bit eh;
    logic [31:0] ePa;
    logic [28:0] eR;
    @(negedge clk);
    idx = mFind(va);
    eh  = (idx >= 0) ? mVal[idx] : 1'b0;
    ePa = eh ? {mFrm[idx], va[11:0]} : 32'h0;
    eR  = eh ? mRts[idx] : 29'h0;
    lkVa = va; lkIsData = isData; lkReq = 1'b1;
    #1;
    chk(lkHit === eh, tag, "hit", 64'(lkHit), 64'(eh));
    chk(lkMissData === (!eh && isData), "R3", "data miss", 64'(lkMissData), 64'(!eh && isData));
    chk(lkMissInstr === (!eh && !isData), "R3", "instr miss", 64'(lkMissInstr), 64'(!eh && !isData));
    chk(lkPa === ePa, tag, "pa", 64'(lkPa), 64'(ePa));
    chk(lkRights === eR, tag, "rights", 64'(lkRights), 64'(eR));
    lkReq = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mReset();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nVec++; nFail++;
    $display("FAIL R11 watchdog: actual %0h expected %0h", 0, 1);
    finish();
  end

  initial begin
    logic [31:0] va;
    logic [31:0] rts;
    void'($urandom(32'h5EED_0042));
    mReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: nothing hits after reset
    chk(cmdDone == 1'b0, "R1", "done after reset", 64'(cmdDone), 64'd0);
    look(pageVa(0, 0), 1'b0, "R1");
    look(32'hFFFF_FFFF, 1'b1, "R1");
    look(32'h0000_0000, 1'b1, "R1");

    // R4, R8: address insert alone stays invalid
    doCmd(1'b0, pageVa(5, 16'h123), {7'h0, 20'hABCDE, 5'h1F}, 1'b0);
    look(pageVa(5, 16'h123), 1'b0, "R4");
    look(pageVa(5, 16'h123), 1'b1, "R4");
    // R9: rights then hit
    rts = 32'h2AAA_5555;
    doCmd(1'b1, pageVa(5, 0), rts, 1'b0);
    look(pageVa(5, 0), 1'b1, "R9");
    chk(lkRights === rts[29:1], "R9", "rights field", 64'(lkRights), 64'(rts[29:1]));
    look(pageVa(5, 16'hFFF), 1'b0, "R8");
    chk(lkPa === {20'hABCDE, 12'hFFF}, "R8", "frame", 64'(lkPa), 64'({20'hABCDE, 12'hFFF}));
    // R2: page edges
    look(pageVa(5, 0) - 32'd1, 1'b1, "R2");
    look(pageVa(6, 0), 1'b0, "R2");

    // R10: unmatched protection and repeated protection
    doCmd(1'b1, pageVa(9, 0), 32'h3FFF_FFFF, 1'b0);
    look(pageVa(9, 4), 1'b1, "R10");
    doCmd(1'b1, pageVa(5, 8), 32'h0000_0002, 1'b0);
    look(pageVa(5, 8), 1'b0, "R10");

    // R5, R12: re-inserting a live page removes the old mapping
    doCmd(1'b0, pageVa(5, 0), {7'h0, 20'h11111, 5'h0}, 1'b0);
    look(pageVa(5, 0), 1'b1, "R5");
    look(pageVa(5, 0), 1'b0, "R12");
    doCmd(1'b1, pageVa(5, 0), 32'h0000_0004, 1'b0);
    look(pageVa(5, 40), 1'b1, "R5");

    // R11: a held request during the done cycle is ignored
    doCmd(1'b0, pageVa(7, 0), {7'h0, 20'h77777, 5'h0}, 1'b0);
    doCmd(1'b1, pageVa(7, 0), 32'h0000_0006, 1'b1);
    @(negedge clk);
    chk(cmdDone == 1'b0, "R11", "ignored second request", 64'(cmdDone), 64'd0);
    chk(seqErr == 1'b0, "R11", "no late seqErr", 64'(seqErr), 64'd0);
    look(pageVa(7, 0), 1'b1, "R11");

    // R6, R7: fill, evict, wrap
    doReset();
    look(pageVa(5, 0), 1'b0, "R1");
    for (int p = 0; p < N; p++) begin
      doCmd(1'b0, pageVa(p, 0), 32'(p + 1) << 5, 1'b0);
      doCmd(1'b1, pageVa(p, 0), 32'(p) << 1, 1'b0);
    end
    for (int p = 0; p < N; p++) look(pageVa(p, p), p[0], "R6");
    for (int p = N; p <= 2 * N; p++) begin
      doCmd(1'b0, pageVa(p, 0), 32'(p + 1) << 5, 1'b0);
      look(pageVa(p, 0), 1'b1, "R7");
      doCmd(1'b1, pageVa(p, 0), 32'(p) << 1, 1'b0);
    end
    for (int p = 0; p <= 2 * N; p++) look(pageVa(p, 3), 1'b0, "R7");
    // the page placed in slot 0 by the first eviction is gone after the wrap
    look(pageVa(N, 0), 1'b0, "R7");
    chk(lkHit == 1'b0, "R7", "wrapped eviction", 64'(lkHit), 64'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      va = pageVa($urandom_range(0, 23), $urandom_range(0, 4095));
      if (op < 3) doCmd(1'b0, va, $urandom, 1'b0);
      else if (op < 6) doCmd(1'b1, va, $urandom, 1'b0);
      else look(va, op[0], "R2");
    end

    finish();
  end

endmodule